// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an on-chip host and an external asynchronous static RAM of 128K bytes. The host raises a request strobe with a direction flag, an address and, for stores, a data byte. The controller then plays out a control sequence on the memory pins and answers with a one-clock completion pulse. Loads return their byte on a held read-data register.

The memory is selected only while its active-low enable is low and its active-high enable is high. It latches write data when its write strobe rises. It drives its data pins only while output enable is low and the write strobe is high. Every timing minimum is given in nanoseconds as a parameter and rounded up to whole clocks at elaboration. Bus turnaround, the write pulse width, data setup and read access time therefore hold for any chosen clock period. Between transfers the chip is deselected so that it rests in standby.

The data bus is split into an input, an output and a pad-driver enable so that the pad cell stays outside the block.

Top module: `sram_ctl`

## Requirements
- R1: While reset is applied, and in the first cycle after it, the outputs are idle: mem_ce_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and done=0.
- R2: The memory is selected (mem_ce_n=0, mem_ce=1) from the first cycle after a request is accepted until the transfer ends. In the cycle where done is high, and with no request pending, it is deselected (mem_ce_n=1, mem_ce=0).
- R3: A store drives mem_we_n low only while both enables are active. For the whole time mem_we_n is low, mem_dq_oe=1 and mem_dq_o carries the request byte. The store ends when mem_we_n rises with the chip still selected, and the memory then holds the byte at the request address.
- R4: mem_we_n stays low for at least N_WP = max(ceil(T_WP/CLK), ceil(T_DW/CLK)) clocks. done rises N_TURN + N_WP + N_WEND clocks after the accepting edge, where N_TURN = ceil(max(T_OHZ,T_WZ)/CLK) and N_WEND = max(1, ceil(T_WC/CLK) - N_TURN - N_WP).
- R5: mem_addr does not change in any cycle in which mem_we_n is low.
- R6: A load drives mem_oe_n low with mem_we_n high and both enables active. It samples mem_dq_i after N_RD = max(ceil(T_AA/CLK), ceil(T_OE/CLK)) clocks of that state, and done and rd_data rise N_RD clocks after the accepting edge.
- R7: mem_we_n and mem_oe_n are never low together. mem_dq_oe turns on only while mem_oe_n is high and at least N_TURN clocks after mem_oe_n last went high.
- R8: A request is taken only when no transfer is in progress. A req raised during a transfer causes no memory write and no extra done pulse.
- R9: done is high for exactly one clock per transfer. rd_data keeps the last loaded byte through later stores until the next load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request strobe, sampled when idle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Store data |
| rd_data | output | DW | Byte from the latest completed load |
| done | output | 1 | One-clock completion pulse |
| mem_addr | output | AW | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | DW | Data toward the pad driver |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_i | input | DW | Data received from the pad |

## Verification
The hardest situation to reach is a store that follows a load right away. Only there do the turnaround wait and the exclusion of the two strobes matter. The random mix of loads and stores over a small address pool places many stores directly behind loads, and directed back-to-back pairs cover the same case. A second hard case is a request raised while a store is running. A directed case drives a second store to another address during the busy cycles and drops it before the controller returns to idle. A later load then shows that the second store never reached the memory.

// File: rtl/sram_ctl_pkg.sv
// Package: shared state encoding and elaboration-time helpers for the
// asynchronous SRAM controller. Assumes non-negative integer arguments.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_WSET = 3'd1,
        S_WPUL = 3'd2,
        S_WEND = 3'd3,
        S_RD   = 3'd4
    } state_t;

    // Integer division rounded up, used to turn ns minimums into clocks.
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Module: down-counting wait-state timer. A load sets the count and the
// timer reports expiry while the count is zero. Assumes that load values
// fit in CW bits.
module sram_ctl_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    // Count down to zero, restarting on load.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    // Expiry flag for the sequencer.
    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
// Module: transfer sequencer. It walks a store through setup, pulse and
// end phases, and a load through a single access phase, with each phase
// held for a clock count given by parameters. Assumes every count >= 1.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CW     = 3,
    parameter int N_TURN = 2,
    parameter int N_WP   = 2,
    parameter int N_WEND = 1,
    parameter int N_RD   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic          expired,
    output state_t        st,
    output state_t        st_nxt,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val
);

    // Next-state and timer-load decode.
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            S_IDLE: if (req) begin
                tmr_load = 1'b1;
                if (req_we) begin
                    st_nxt  = S_WSET;
                    tmr_val = CW'(N_TURN - 1);
                end else begin
                    st_nxt  = S_RD;
                    tmr_val = CW'(N_RD - 1);
                end
            end
            S_WSET: if (expired) begin
                st_nxt   = S_WPUL;
                tmr_load = 1'b1;
                tmr_val  = CW'(N_WP - 1);
            end
            S_WPUL: if (expired) begin
                st_nxt   = S_WEND;
                tmr_load = 1'b1;
                tmr_val  = CW'(N_WEND - 1);
            end
            S_WEND:  if (expired) st_nxt = S_IDLE;
            S_RD:    if (expired) st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nxt;
    end

endmodule

// File: rtl/sram_ctl.sv
// Module: asynchronous SRAM access controller (top). It converts single
// byte host requests into registered, glitch-free memory control
// sequences. Timing minimums are given in ns and rounded up to clocks.
// Assumes the host holds req_* stable in the cycle req is high.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW       = 17,
    parameter int DW       = 8,
    parameter int CLK_NS   = 4,
    parameter int T_WP_NS  = 7,
    parameter int T_WC_NS  = 10,
    parameter int T_DW_NS  = 6,
    parameter int T_AA_NS  = 10,
    parameter int T_OE_NS  = 3,
    parameter int T_OHZ_NS = 3,
    parameter int T_WZ_NS  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_ce,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);

    localparam int N_TURN = imax(1, cdiv(imax(T_OHZ_NS, T_WZ_NS), CLK_NS));
    localparam int N_WP   = imax(1, imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_DW_NS, CLK_NS)));
    localparam int N_WEND = imax(1, cdiv(T_WC_NS, CLK_NS) - N_TURN - N_WP);
    localparam int N_RD   = imax(1, imax(cdiv(T_AA_NS, CLK_NS), cdiv(T_OE_NS, CLK_NS)));
    localparam int N_MAX  = imax(imax(N_TURN, N_WP), imax(N_WEND, N_RD));
    localparam int CW     = $clog2(N_MAX + 1);

    state_t        st, st_nxt;
    logic          tmr_load, tmr_exp;
    logic [CW-1:0] tmr_val;
    logic          accept;
    logic          finish;

    sram_ctl_fsm #(
        .CW(CW), .N_TURN(N_TURN), .N_WP(N_WP), .N_WEND(N_WEND), .N_RD(N_RD)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .expired(tmr_exp), .st(st), .st_nxt(st_nxt),
        .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    sram_ctl_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_exp)
    );

    assign accept = (st == S_IDLE) && req;
    assign finish = tmr_exp && ((st == S_WEND) || (st == S_RD));

    // Memory-side control lines, registered from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_ce    <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= (st_nxt == S_IDLE);
            mem_ce    <= (st_nxt != S_IDLE);
            mem_we_n  <= (st_nxt != S_WPUL);
            mem_oe_n  <= (st_nxt != S_RD);
            mem_dq_oe <= (st_nxt == S_WPUL) || (st_nxt == S_WEND);
        end
    end

    // Address and store data, captured only when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
        end
    end

    // Completion pulse and held load data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= finish;
            if (tmr_exp && (st == S_RD)) rd_data <= mem_dq_i;
        end
    end

endmodule

// File: rtl/sram_ctl_chk.sv
// Module: protocol checker for sram_ctl, attached by bind. It observes
// the memory pins and the done pulse only. Assumes that the width counts
// stay below 255 clocks.
module sram_ctl_chk #(
    parameter int AW     = 17,
    parameter int N_WP   = 2,
    parameter int N_TURN = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_ce,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe,
    input logic          done
);

    logic [7:0] we_low_cnt;
    logic [7:0] oe_high_cnt;

    // Clocks for which the write strobe has been low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            we_low_cnt <= '0;
        else if (mem_we_n)     we_low_cnt <= '0;
        else if (we_low_cnt != 8'hFF) we_low_cnt <= we_low_cnt + 1'b1;
    end

    // Clocks for which output enable has been high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            oe_high_cnt <= 8'hFF;
        else if (!mem_oe_n)    oe_high_cnt <= '0;
        else if (oe_high_cnt != 8'hFF) oe_high_cnt <= oe_high_cnt + 1'b1;
    end

    AST_WE_SELECTED:  assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (!mem_ce_n && mem_ce && mem_dq_oe)); // R3
    AST_WE_RISE_SEL:  assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (!mem_ce_n && mem_ce)); // R3
    AST_WE_WIDTH:     assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (we_low_cnt >= 8'(N_WP))); // R4
    AST_ADDR_STABLE:  assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |=> (mem_we_n || $stable(mem_addr))); // R5
    AST_READ_SEL:     assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> (!mem_ce_n && mem_ce && mem_we_n)); // R6
    AST_STROBE_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(!mem_we_n && !mem_oe_n)); // R7
    AST_DRV_TURN:     assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_dq_oe) |-> (mem_oe_n && oe_high_cnt >= 8'(N_TURN))); // R7
    AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9

endmodule

bind sram_ctl sram_ctl_chk #(
    .AW(AW), .N_WP(N_WP), .N_TURN(N_TURN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_oe(mem_dq_oe), .done(done)
);

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;

    localparam int CLK_NS = 4;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int T_WP = 7, T_WC = 10, T_DW = 6, T_AA = 10, T_OE = 3, T_OHZ = 3, T_WZ = 5;

    function automatic int up(input int n);
        return (n + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_TURN = mx(1, up(mx(T_OHZ, T_WZ)));
    localparam int E_WP   = mx(1, mx(up(T_WP), up(T_DW)));
    localparam int E_WEND = mx(1, up(T_WC) - E_TURN - E_WP);
    localparam int E_RD   = mx(1, mx(up(T_AA), up(T_OE)));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic done;
    logic [AW-1:0] mem_addr;
    logic mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    int n_chk = 0;
    int n_err = 0;
    bit ended = 0;

    always #(CLK_NS / 2) clk = ~clk;

    sram_ctl #(.AW(AW), .DW(DW), .CLK_NS(CLK_NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .done(done), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural memory: stores on the rising write strobe, drives data T_AA after OE falls.
    logic [DW-1:0] model_mem [logic [AW-1:0]];
    logic [DW-1:0] shadow [logic [AW-1:0]];
    logic drv_valid = 1'b0;
    logic [DW-1:0] drv_data = '0;
    assign mem_dq_i = drv_valid ? drv_data : 8'hEE;

    function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
        return model_mem.exists(a) ? model_mem[a] : 8'hFF;
    endfunction
    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        return shadow.exists(a) ? shadow[a] : 8'hFF;
    endfunction

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n && mem_ce) model_mem[mem_addr] = mem_dq_o;
    end
    always begin
        @(negedge mem_oe_n);
        #(T_AA);
        if (!mem_oe_n && !mem_ce_n && mem_ce && mem_we_n) begin
            drv_data = model_rd(mem_addr);
            drv_valid = 1'b1;
        end
    end
    always @(posedge mem_oe_n) drv_valid = 1'b0;

    // Pin monitor sampled away from the active edge.
    int we_run = 0, oe_high_run = 100;
    logic prev_we_low = 1'b0, prev_dq_oe = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n || !mem_oe_n)
                check(!(!mem_we_n && !mem_oe_n), "R7 strobes", {mem_we_n, mem_oe_n}, 1);
            if (!mem_we_n)
                check(!mem_ce_n && mem_ce && mem_dq_oe, "R3 select during pulse", {mem_ce_n, mem_ce, mem_dq_oe}, 3'b011);
            if (!mem_we_n && prev_we_low)
                check(mem_addr == prev_addr, "R5 address stable", mem_addr, prev_addr);
            if (mem_we_n && we_run > 0)
                check(we_run >= E_WP, "R4 pulse width", we_run, E_WP);
            if (mem_dq_oe && !prev_dq_oe)
                check(mem_oe_n && oe_high_run >= E_TURN, "R7 turnaround", oe_high_run, E_TURN);
        end
        we_run = mem_we_n ? 0 : we_run + 1;
        oe_high_run = mem_oe_n ? oe_high_run + 1 : 0;
        prev_we_low = !mem_we_n;
        prev_dq_oe = mem_dq_oe;
        prev_addr = mem_addr;
    end

    // One transfer: request for one clock, measure latency, check completion.
    task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat;
        int exp_lat;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        check(!mem_ce_n && mem_ce, "R2 selected", {mem_ce_n, mem_ce}, 2'b01);
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = we ? (E_TURN + E_WP + E_WEND + 1) : (E_RD + 1);
        check(lat == exp_lat, we ? "R4 store latency" : "R6 load latency", lat, exp_lat);
        check(mem_ce_n && !mem_ce, "R2 standby", {mem_ce_n, mem_ce}, 2'b10);
        if (we) begin
            shadow[a] = d;
            check(model_rd(a) == d, "R3 memory content", model_rd(a), d);
        end else begin
            check(rd_data == exp_rd(a), "R6 load data", rd_data, exp_rd(a));
        end
        @(negedge clk);
        check(!done, "R9 single pulse", done, 0);
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!ended) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] pool [8];
        logic [DW-1:0] held;
        int dn;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && !done, "R1 reset idle",
              {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, done}, 6'b101100);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && !done, "R1 after reset",
              {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, done}, 6'b101100);

        // Directed: address extremes, store then load back to back.
        do_op(1'b1, 17'h00000, 8'h3C);
        do_op(1'b1, 17'h1FFFF, 8'hC3);
        do_op(1'b0, 17'h00000, 8'h00);
        do_op(1'b1, 17'h00000, 8'h5A);
        do_op(1'b0, 17'h1FFFF, 8'h00);
        do_op(1'b0, 17'h00000, 8'h00);

        // R9: loaded byte survives a following store.
        held = rd_data;
        do_op(1'b1, 17'h00123, 8'h77);
        check(rd_data == held, "R9 rd_data held", rd_data, held);

        // R8: second request during a store is ignored.
        do_op(1'b1, 17'h00456, 8'h11);
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 17'h00789; req_wdata = 8'hAB;
        @(negedge clk);
        req_addr = 17'h00456; req_wdata = 8'h99;
        @(negedge clk);
        req = 1'b0;
        dn = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (done) dn++;
        end
        check(dn == 1, "R8 one done only", dn, 1);
        shadow[17'h00789] = 8'hAB;
        do_op(1'b0, 17'h00789, 8'h00);
        do_op(1'b0, 17'h00456, 8'h00);

        // Constrained random mix over a small pool.
        pool[0] = 17'h00000;
        pool[7] = 17'h1FFFF;
        for (int i = 1; i < 7; i++) pool[i] = AW'($urandom);
        for (int i = 0; i < 80; i++) begin
            int k;
            k = int'($urandom % 8);
            do_op(($urandom % 2) == 1, pool[k], DW'($urandom));
        end

        ended = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule